// File: doc/BRIEF.md
# Strobe-Latched Digital Input and Output Port

This block gives a host a 32-bit digital output port and a 32-bit digital input port, both reached one byte at a time over an 8-bit synchronous bus. There are four byte offsets. A write to an offset loads the matching output byte. A read from an offset returns the matching input byte.

The input pins are split into a low half and a high half. Each half has its own strobe pin. While a strobe is high, reads of its half return the live pin levels after synchronisation. When a strobe goes from high to low, the pins of its half are frozen into a holding register. Reads of that half then return the frozen snapshot for as long as the strobe stays low. A strobe that nobody drives is expected to sit high, through a board pull-up, so its half stays transparent.

All pins are asynchronous to the block clock. They pass through two-flop synchronisers, and strobe edges are detected after synchronisation.

Top module: `strobe_dio_port`

## Requirements
- R1: A write (bus_sel and bus_wr high at a clock edge) to offset k loads bus_wdata into dout[8k+7:8k], with bus_wdata bit 0 driving the lowest channel of that byte; k is 0 to 3.
- R2: A read from offset k returns input channels 8k to 8k+7, with channel 8k on bus_rdata bit 0.
- R3: strobe[0] controls only din[15:0] (offsets 0 and 1), and strobe[1] controls only din[31:16] (offsets 2 and 3); the two halves capture and release independently.
- R4: While a half's strobe is high, a read of that half returns the pin levels after the two-flop synchroniser, as sampled in the read cycle; pins held stable for three clocks are visible.
- R5: A high-to-low strobe transition (seen after synchronisation) captures that half's synchronised pins; while the strobe stays low, reads of the half return the capture even if the pins change.
- R6: When the strobe returns high, reads of its half again follow the live pins.
- R7: During reset, dout and bus_rdata are zero and both strobe synchronisers are preset high, so both halves leave reset transparent and reset release alone never causes a capture.
- R8: An output byte holds its value until the same offset is written again; a write to one offset leaves the other three bytes unchanged.
- R9: bus_rdata is registered: it takes the read byte at the edge that samples a read (bus_sel and bus_rd high) and holds its value in every cycle without a read.
- R10: With bus_sel low, bus_wr and bus_rd have no effect: dout and bus_rdata do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Host select; qualifies reads and writes |
| bus_wr | input | 1 | Write request, sampled at the clock edge |
| bus_rd | input | 1 | Read request, sampled at the clock edge |
| bus_addr | input | 2 | Byte offset 0 to 3 |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| din | input | 32 | Asynchronous input pins, channel n on bit n |
| strobe | input | 2 | Per-half latch strobes; bit 0 for the low half, bit 1 for the high half |
| dout | output | 32 | Output channels, channel n on bit n |

## Verification
The assertions assume that the bus controls are synchronous to clk. They also assume that strobe and pin changes are slow compared with the synchroniser, so the capture register always loads a settled synchronised value. The stimulus changes pins and strobes at clock midpoints and then waits at least four clocks before reading or changing anything else. After a strobe falls, the pins stay unchanged for four clocks before the new values are applied. This makes the expected snapshot the set of pins present when the strobe fell.

// File: rtl/dio_pkg.sv
// Package dio_pkg
// Shared widths and the host byte type for the strobe-latched digital port.
// Assumes an 8-bit host data path.
package dio_pkg;
    localparam int HOST_W = 8;
    typedef logic [HOST_W-1:0] host_byte_t;
endpackage

// File: rtl/dio_sync.sv
// Module dio_sync
// Multi-stage synchroniser for a vector of asynchronous pins. The reset value
// is a parameter, so a strobe can be preset high (transparent).
// Assumes each bit is independent; no bus coherency is provided.
module dio_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the pin values through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dio_in_group.sv
// Module dio_in_group
// One input half: synchronises its pins and its strobe, detects the strobe
// falling edge, keeps a snapshot, and presents either live or frozen data.
// Assumes pins are stable around the strobe edge for the synchroniser depth.
module dio_in_group #(
    parameter int GROUP_W = 16,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [GROUP_W-1:0] pins,
    input  logic               stb,
    output logic [GROUP_W-1:0] view
);
    logic [GROUP_W-1:0] live;
    logic [GROUP_W-1:0] hold;
    logic               stb_s;
    logic               stb_q;
    logic               fall;

    dio_sync #(.W(GROUP_W), .STAGES(STAGES), .RST_VAL('0)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(pins), .q(live)
    );

    dio_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b1)) u_stb_sync (
        .clk(clk), .rst_n(rst_n), .d(stb), .q(stb_s)
    );

    // Remember the previous synchronised strobe level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b1;
        else        stb_q <= stb_s;
    end

    assign fall = stb_q & ~stb_s;

    // Freeze the synchronised pins on the strobe falling edge
    always_ff @(posedge clk) begin
        if (!rst_n)    hold <= '0;
        else if (fall) hold <= live;
    end

    // Transparent while high; in the edge cycle live equals what is captured
    always_comb begin
        view = (stb_s | fall) ? live : hold;
    end

    // R5: the snapshot holds while the strobe stays low
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb_s && !stb_q) |=> (!stb_s ? $stable(hold) : 1'b1));

    // R5: a falling edge loads the synchronised pins present in that cycle
    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> (hold == $past(live)));

    // R7: a capture needs the strobe to have been high first
    a_r7_no_spurious_fall: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> $past(stb_s));
endmodule

// File: rtl/dio_out_regs.sv
// Module dio_out_regs
// Byte-writable output register bank. Each byte loads only on a write to its
// own offset and otherwise keeps its value.
// Assumes wr_en is already qualified by the host select.
module dio_out_regs
    import dio_pkg::*;
#(
    parameter int N_BYTES = 4,
    parameter int ADDR_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  host_byte_t              wdata,
    output logic [N_BYTES*HOST_W-1:0] dout
);
    for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
        // Load this byte on a write addressed to it
        always_ff @(posedge clk) begin
            if (!rst_n)
                dout[b*HOST_W +: HOST_W] <= '0;
            else if (wr_en && (addr == ADDR_W'(b)))
                dout[b*HOST_W +: HOST_W] <= wdata;
        end

        // R1: an addressed write lands in its byte
        a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (addr == ADDR_W'(b))) |=> (dout[b*HOST_W +: HOST_W] == $past(wdata)));

        // R8: other offsets leave this byte untouched
        a_r8_byte_isolated: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (addr != ADDR_W'(b))) |=> $stable(dout[b*HOST_W +: HOST_W]));
    end

    // R10: without a write nothing in the bank moves
    a_r10_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(dout));
endmodule

// File: rtl/strobe_dio_port.sv
// Module strobe_dio_port
// Byte-addressed 32-bit output and strobe-latched 32-bit input port on an
// 8-bit synchronous host bus. Inputs are split into halves, each with its own
// strobe that switches between live reads and a falling-edge snapshot.
// Assumes bus controls are synchronous to clk; pins and strobes are not.
module strobe_dio_port
    import dio_pkg::*;
#(
    parameter int N_GROUPS = 2,
    parameter int GROUP_W  = 16,
    parameter int STAGES   = 2,
    localparam int PORT_W  = N_GROUPS * GROUP_W,
    localparam int N_BYTES = PORT_W / HOST_W,
    localparam int ADDR_W  = $clog2(N_BYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [HOST_W-1:0]   bus_wdata,
    output logic [HOST_W-1:0]   bus_rdata,
    input  logic [PORT_W-1:0]   din,
    input  logic [N_GROUPS-1:0] strobe,
    output logic [PORT_W-1:0]   dout
);
    logic [PORT_W-1:0] in_view;
    logic              wr_en;
    logic              rd_en;

    assign wr_en = bus_sel & bus_wr;
    assign rd_en = bus_sel & bus_rd;

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        dio_in_group #(.GROUP_W(GROUP_W), .STAGES(STAGES)) u_grp (
            .clk  (clk),
            .rst_n(rst_n),
            .pins (din[g*GROUP_W +: GROUP_W]),
            .stb  (strobe[g]),
            .view (in_view[g*GROUP_W +: GROUP_W])
        );
    end

    dio_out_regs #(.N_BYTES(N_BYTES), .ADDR_W(ADDR_W)) u_out (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_en),
        .addr (bus_addr),
        .wdata(bus_wdata),
        .dout (dout)
    );

    // Register the addressed input byte on a qualified read
    always_ff @(posedge clk) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (rd_en) bus_rdata <= in_view[bus_addr*HOST_W +: HOST_W];
    end

    // R9: read data only moves on a qualified read
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(bus_rdata));

    // R10: a read or write without select changes no output
    a_r10_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> ($stable(bus_rdata) && $stable(dout)));

    // R7: the first cycle out of reset shows cleared outputs
    a_r7_reset_clear: assert property (@(posedge clk)
        $past(!rst_n) |-> (dout == '0 && bus_rdata == '0));
endmodule

// File: tb/tb_strobe_dio_port.sv
module tb_strobe_dio_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [31:0] din = '0;
    logic [1:0]  strobe = 2'b11;
    logic [31:0] dout;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    strobe_dio_port dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .din(din), .strobe(strobe), .dout(dout)
    );

    // kind[43:42] 0=write 1=set pins 2=read; addr[41:40]; data[39:8]; byte[7:0]
    localparam int NV = 12;
    localparam logic [43:0] VEC [NV] = '{
        {2'd1, 2'd0, 32'h1234_5678, 8'h00},
        {2'd2, 2'd0, 32'h0,         8'h78},
        {2'd2, 2'd3, 32'h0,         8'h12},
        {2'd0, 2'd0, 32'h0000_00A1, 8'hA1},
        {2'd0, 2'd2, 32'h005C_00A1, 8'h5C},
        {2'd0, 2'd0, 32'h005C_003E, 8'h3E},
        {2'd1, 2'd0, 32'hF00F_8001, 8'h00},
        {2'd2, 2'd1, 32'h0,         8'h80},
        {2'd2, 2'd2, 32'h0,         8'h0F},
        {2'd2, 2'd3, 32'h0,         8'hF0},
        {2'd2, 2'd0, 32'h0,         8'h01},
        {2'd0, 2'd3, 32'h995C_003E, 8'h99}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d, input bit sel);
        @(negedge clk);
        bus_sel = sel; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] a, input bit sel, output logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] rb;
        logic [7:0] prev;
        repeat (3) @(negedge clk);
        chk(dout == 32'h0, "R7 dout in reset", dout, 32'h0);
        chk(bus_rdata == 8'h0, "R7 rdata in reset", {24'h0, bus_rdata}, 32'h0);
        rst_n = 1'b1;
        din = 32'hCAFE_BABE;
        settle();
        // R7: both halves transparent after reset with strobes high
        do_read(2'd1, 1'b1, rb);
        chk(rb == 8'hBA, "R7 transparent after reset", {24'h0, rb}, 32'hBA);

        // Table walk: R1 R2 R4 R8
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][43:42])
                2'd0: begin
                    do_write(VEC[i][41:40], VEC[i][7:0], 1'b1);
                    chk(dout == VEC[i][39:8], "R1 R8 write table", dout, VEC[i][39:8]);
                end
                2'd1: begin
                    @(negedge clk); din = VEC[i][39:8]; settle();
                end
                default: begin
                    do_read(VEC[i][41:40], 1'b1, rb);
                    chk(rb == VEC[i][7:0], "R2 R4 read table", {24'h0, rb}, {24'h0, VEC[i][7:0]});
                end
            endcase
        end

        // R5 R3: freeze low half
        @(negedge clk); din = 32'h1111_2222; settle();
        strobe[0] = 1'b0; settle();
        din = 32'h3333_4444; settle();
        do_read(2'd0, 1'b1, rb);
        chk(rb == 8'h22, "R5 low half frozen byte0", {24'h0, rb}, 32'h22);
        do_read(2'd1, 1'b1, rb);
        chk(rb == 8'h22, "R5 low half frozen byte1", {24'h0, rb}, 32'h22);
        do_read(2'd2, 1'b1, rb);
        chk(rb == 8'h33, "R3 high half still live", {24'h0, rb}, 32'h33);

        // R3: freeze high half independently
        strobe[1] = 1'b0; settle();
        din = 32'h5555_6666; settle();
        do_read(2'd3, 1'b1, rb);
        chk(rb == 8'h33, "R3 high half frozen", {24'h0, rb}, 32'h33);
        do_read(2'd0, 1'b1, rb);
        chk(rb == 8'h22, "R5 low half snapshot kept", {24'h0, rb}, 32'h22);

        // R6: release low half
        strobe[0] = 1'b1; settle();
        do_read(2'd0, 1'b1, rb);
        chk(rb == 8'h66, "R6 low half live again", {24'h0, rb}, 32'h66);
        do_read(2'd2, 1'b1, rb);
        chk(rb == 8'h33, "R3 high half unaffected by strobe0", {24'h0, rb}, 32'h33);
        strobe[1] = 1'b1; settle();
        do_read(2'd3, 1'b1, rb);
        chk(rb == 8'h55, "R6 high half live again", {24'h0, rb}, 32'h55);

        // R9: rdata holds without reads while pins change
        prev = bus_rdata;
        din = 32'h0; settle();
        chk(bus_rdata == prev, "R9 rdata held", {24'h0, bus_rdata}, {24'h0, prev});

        // R10: unselected write and read are ignored
        do_write(2'd1, 8'hEE, 1'b0);
        chk(dout == 32'h995C_003E, "R10 unselected write", dout, 32'h995C_003E);
        do_read(2'd0, 1'b0, rb);
        chk(rb == prev, "R10 unselected read", {24'h0, rb}, {24'h0, prev});

        // R8: rewrite one byte, others kept
        do_write(2'd1, 8'h7D, 1'b1);
        chk(dout == 32'h995C_7D3E, "R8 single byte rewrite", dout, 32'h995C_7D3E);

        // R7: reset clears outputs again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk(dout == 32'h0, "R7 dout cleared", dout, 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule